// File: doc/BRIEF.md
# ADC Range and Power-Mode Sequencer

This block sits between a conversion scheduler and an external converter. It owns the converter's two gain-select lines and its low-power lines. Software-free control logic sends it one-cycle requests for a new gain range or a new power state (active, nap or sleep). The block drives the new levels onto the pins. It then keeps its `ready` output low for a settling interval whose length depends on the transition. A slow reference discharge, a fast reference charge, a change through the divided reference node, and a wake from deep or light shutdown each have their own wait.

Every wait is given in nanoseconds as a parameter and is converted to clock cycles from the `CLK_HZ` parameter, so the same code serves any system clock. A request that arrives during a wait is held, and it takes effect when that wait ends. If both a gain and a power request are held, they are applied together, and the longer of their two waits is used. Conversion requests from the scheduler pass through to `conv_go_o` only while the block is ready.

Top module: `adc_range_sequencer`

## Requirements
- R1: The gain pins `rng_sel_o[1:0]` encode four levels: 2'b11 = 0 dB, 2'b01 = -3 dB (bit 0 high, bit 1 low), 2'b10 = -6 dB, 2'b00 = -9 dB. The code on `rng_code_i` appears on the pins in the cycle after a `rng_req_i` pulse that is sampled while idle.
- R2: A change from -3 dB to 0 dB holds `ready_o` low for RISE cycles, where the cycles for a wait of T ns are ceil(CLK_HZ*T/1e9), with a minimum of 1.
- R3: A change from 0 dB to -3 dB holds `ready_o` low for FALL cycles.
- R4: Any gain change in which the old or the new level is -6 dB or -9 dB holds `ready_o` low for DEEP cycles.
- R5: Power codes are 2'b00 active, 2'b01 nap and 2'b10 sleep. Sleep drives `sleep_n_o` low, and nap drives `nap_o` high. The two are never asserted together. `ready_o` is low whenever the state is not active. Entering nap or sleep adds no wait. A power request with code 2'b11 is ignored.
- R6: Going from sleep to active holds `ready_o` low for SLEEP cycles. Going from nap to active holds it low for NAP cycles.
- R7: A request for the gain or power state already in effect changes no pin and does not drop `ready_o`.
- R8: A request that arrives during a wait is held, and the pins keep their values. When the wait ends, the held request is applied and a new wait starts for that transition. A later request of the same kind replaces an earlier held one.
- R9: `ready_o` rises exactly one cycle after the wait counter reaches its terminal count, so a wait of W cycles gives W low cycles after the applying edge. `conv_go_o` equals `conv_req_i` while ready and is low otherwise.
- R10: Reset selects 0 dB and active, with `ready_o` low. The first SLEEP cycles after reset is released count as a start-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rng_req_i | input | 1 | One-cycle gain change request |
| rng_code_i | input | 2 | Requested gain code (R1 encoding) |
| pwr_req_i | input | 1 | One-cycle power state request |
| pwr_code_i | input | 2 | Requested power code (R5 encoding) |
| conv_req_i | input | 1 | Conversion request from the scheduler |
| rng_sel_o | output | 2 | Gain-select pins to the converter |
| sleep_n_o | output | 1 | Sleep line, low puts the converter to sleep |
| nap_o | output | 1 | Nap line, high selects nap |
| ready_o | output | 1 | Converter settled and active |
| conv_go_o | output | 1 | Conversion start, gated by ready |

## Verification
The bench builds the block with `CLK_HZ` = 10 000. The waits then become 6 (rise), 110 (fall), 7000 (deep), 2100 (sleep) and 1 (nap) cycles. With five distinct lengths, a wrong wait selection always shows up as a wrong count. The full 700 ms deep wait is measured exactly, cycle by cycle, several times within the run. The nap wake rounds up to the one-cycle minimum, which exercises the terminal-count corner. A held request is followed through a 6-cycle wait into a 110-cycle wait, which checks both the hold and the restart of the timer.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        GAIN_M9 = 2'b00,
        GAIN_M3 = 2'b01,
        GAIN_M6 = 2'b10,
        GAIN_0  = 2'b11
    } gain_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'b00,
        PWR_NAP    = 2'b01,
        PWR_SLEEP  = 2'b10,
        PWR_RSVD   = 2'b11
    } pwr_e;

    // Clock cycles covering a wait of ns nanoseconds, rounded up, at least one.
    function automatic longint ns_to_cycles(input longint clk_hz, input longint ns);
        longint c;
        c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/adc_seq_range_wait.sv
module adc_seq_range_wait
    import adc_seq_pkg::*;
#(
    parameter int               CNT_W    = 8,
    parameter logic [CNT_W-1:0] RISE_CYC = '0,
    parameter logic [CNT_W-1:0] FALL_CYC = '0,
    parameter logic [CNT_W-1:0] DEEP_CYC = '0
) (
    input  gain_e            cur_i,
    input  gain_e            nxt_i,
    output logic [CNT_W-1:0] cyc_o
);

    logic touches_div;

    always_comb begin
        touches_div = (cur_i == GAIN_M6) || (cur_i == GAIN_M9) ||
                      (nxt_i == GAIN_M6) || (nxt_i == GAIN_M9);
        if (cur_i == nxt_i) begin
            cyc_o = '0;
        end else if (touches_div) begin
            cyc_o = DEEP_CYC;
        end else if ((cur_i == GAIN_M3) && (nxt_i == GAIN_0)) begin
            cyc_o = RISE_CYC;
        end else begin
            cyc_o = FALL_CYC;
        end
    end

endmodule

// File: rtl/adc_seq_mode_wait.sv
module adc_seq_mode_wait
    import adc_seq_pkg::*;
#(
    parameter int               CNT_W     = 8,
    parameter logic [CNT_W-1:0] NAP_CYC   = '0,
    parameter logic [CNT_W-1:0] SLEEP_CYC = '0
) (
    input  pwr_e             cur_i,
    input  pwr_e             nxt_i,
    output logic [CNT_W-1:0] cyc_o
);

    always_comb begin
        if (cur_i == nxt_i) begin
            cyc_o = '0;
        end else if (cur_i == PWR_SLEEP) begin
            cyc_o = SLEEP_CYC;
        end else if ((cur_i == PWR_NAP) && (nxt_i == PWR_ACTIVE)) begin
            cyc_o = NAP_CYC;
        end else begin
            cyc_o = '0;
        end
    end

endmodule

// File: rtl/adc_range_sequencer.sv
module adc_range_sequencer
    import adc_seq_pkg::*;
#(
    parameter longint CLK_HZ   = 100_000_000,
    parameter longint RISE_NS  = 600_000,
    parameter longint FALL_NS  = 11_000_000,
    parameter longint DEEP_NS  = 700_000_000,
    parameter longint SLEEP_NS = 210_000_000,
    parameter longint NAP_NS   = 250
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rng_req_i,
    input  logic [1:0] rng_code_i,
    input  logic       pwr_req_i,
    input  logic [1:0] pwr_code_i,
    input  logic       conv_req_i,
    output logic [1:0] rng_sel_o,
    output logic       sleep_n_o,
    output logic       nap_o,
    output logic       ready_o,
    output logic       conv_go_o
);

    localparam longint RISE_C  = ns_to_cycles(CLK_HZ, RISE_NS);
    localparam longint FALL_C  = ns_to_cycles(CLK_HZ, FALL_NS);
    localparam longint DEEP_C  = ns_to_cycles(CLK_HZ, DEEP_NS);
    localparam longint SLEEP_C = ns_to_cycles(CLK_HZ, SLEEP_NS);
    localparam longint NAP_C   = ns_to_cycles(CLK_HZ, NAP_NS);
    localparam longint MAX_AB  = (RISE_C > FALL_C) ? RISE_C : FALL_C;
    localparam longint MAX_CD  = (DEEP_C > SLEEP_C) ? DEEP_C : SLEEP_C;
    localparam longint MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam longint MAX_C   = (MAX_ABCD > NAP_C) ? MAX_ABCD : NAP_C;
    localparam int     CNT_W   = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0] RISE_V  = CNT_W'(RISE_C);
    localparam logic [CNT_W-1:0] FALL_V  = CNT_W'(FALL_C);
    localparam logic [CNT_W-1:0] DEEP_V  = CNT_W'(DEEP_C);
    localparam logic [CNT_W-1:0] SLEEP_V = CNT_W'(SLEEP_C);
    localparam logic [CNT_W-1:0] NAP_V   = CNT_W'(NAP_C);

    typedef struct packed {
        gain_e            gain;
        pwr_e             pwr;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             hold_g_v;
        gain_e            hold_g;
        logic             hold_p_v;
        pwr_e             hold_p;
        logic             ready;
    } seq_st_t;

    localparam seq_st_t RST_ST = '{
        gain:     GAIN_0,
        pwr:      PWR_ACTIVE,
        busy:     1'b1,
        cnt:      SLEEP_V,
        hold_g_v: 1'b0,
        hold_g:   GAIN_0,
        hold_p_v: 1'b0,
        hold_p:   PWR_ACTIVE,
        ready:    1'b0
    };

    seq_st_t st_d, st_q;

    logic             pwr_ok;
    logic             eff_g_v, eff_p_v;
    gain_e            eff_g, tgt_g;
    pwr_e             eff_p, tgt_p;
    logic [CNT_W-1:0] g_cyc, p_cyc, w_cyc;
    logic             at_term, apply;

    // Merge a fresh request with any held one; a fresh one wins.
    always_comb begin
        pwr_ok  = pwr_req_i && (pwr_e'(pwr_code_i) != PWR_RSVD);
        eff_g_v = rng_req_i || st_q.hold_g_v;
        eff_g   = rng_req_i ? gain_e'(rng_code_i) : st_q.hold_g;
        eff_p_v = pwr_ok || st_q.hold_p_v;
        eff_p   = pwr_ok ? pwr_e'(pwr_code_i) : st_q.hold_p;
        tgt_g   = eff_g_v ? eff_g : st_q.gain;
        tgt_p   = eff_p_v ? eff_p : st_q.pwr;
    end

    adc_seq_range_wait #(
        .CNT_W    (CNT_W),
        .RISE_CYC (RISE_V),
        .FALL_CYC (FALL_V),
        .DEEP_CYC (DEEP_V)
    ) u_rwait (
        .cur_i (st_q.gain),
        .nxt_i (tgt_g),
        .cyc_o (g_cyc)
    );

    adc_seq_mode_wait #(
        .CNT_W     (CNT_W),
        .NAP_CYC   (NAP_V),
        .SLEEP_CYC (SLEEP_V)
    ) u_mwait (
        .cur_i (st_q.pwr),
        .nxt_i (tgt_p),
        .cyc_o (p_cyc)
    );

    always_comb begin
        w_cyc   = (g_cyc > p_cyc) ? g_cyc : p_cyc;
        at_term = st_q.busy && (st_q.cnt == CNT_W'(1));
        apply   = !st_q.busy || at_term;

        st_d = st_q;
        if (!apply) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (rng_req_i) begin
                st_d.hold_g_v = 1'b1;
                st_d.hold_g   = gain_e'(rng_code_i);
            end
            if (pwr_ok) begin
                st_d.hold_p_v = 1'b1;
                st_d.hold_p   = pwr_e'(pwr_code_i);
            end
        end else begin
            st_d.gain     = tgt_g;
            st_d.pwr      = tgt_p;
            st_d.hold_g_v = 1'b0;
            st_d.hold_p_v = 1'b0;
            st_d.busy     = (w_cyc != '0);
            st_d.cnt      = w_cyc;
        end
        st_d.ready = !st_d.busy && (st_d.pwr == PWR_ACTIVE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rng_sel_o = st_q.gain;
    assign sleep_n_o = (st_q.pwr != PWR_SLEEP);
    assign nap_o     = (st_q.pwr == PWR_NAP);
    assign ready_o   = st_q.ready;
    assign conv_go_o = conv_req_i && st_q.ready;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] rng_sel_o,
    input logic       sleep_n_o,
    input logic       nap_o,
    input logic       ready_o
);

    // R5
    sleep_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sleep_n_o |-> !ready_o);

    // R5
    nap_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nap_o |-> !ready_o);

    // R5
    mode_pins_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(nap_o && !sleep_n_o));

    // R4
    range_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rng_sel_o != $past(rng_sel_o)) |-> !ready_o);

    // R6
    wake_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sleep_n_o) |-> !ready_o);

endmodule

bind adc_range_sequencer adc_seq_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rng_sel_o (rng_sel_o),
    .sleep_n_o (sleep_n_o),
    .nap_o     (nap_o),
    .ready_o   (ready_o)
);

// File: tb/sim_adc_range_sequencer.sv
module sim_adc_range_sequencer;

    localparam longint HZ = 10_000;

    function automatic int cyc(input longint ns);
        longint c;
        c = (HZ * ns + 999_999_999) / 1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int W_RISE  = cyc(600_000);
    localparam int W_FALL  = cyc(11_000_000);
    localparam int W_DEEP  = cyc(700_000_000);
    localparam int W_SLEEP = cyc(210_000_000);
    localparam int W_NAP   = cyc(250);
    localparam int LIMIT   = 20000;

    typedef struct packed {
        logic [1:0] code;
        int         wait_c;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b01, W_FALL},  // R3: 0 dB -> -3 dB
        '{2'b11, W_RISE},  // R2: -3 dB -> 0 dB
        '{2'b10, W_DEEP},  // R4: into -6 dB
        '{2'b00, W_DEEP},  // R4: -6 dB -> -9 dB
        '{2'b00, 0},       // R7: same level
        '{2'b01, W_DEEP}   // R4: out of -9 dB
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rng_req = 1'b0;
    logic [1:0] rng_code = 2'b11;
    logic       pwr_req = 1'b0;
    logic [1:0] pwr_code = 2'b00;
    logic       conv_req = 1'b0;
    logic [1:0] rng_sel;
    logic       sleep_n, nap, ready, conv_go;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    adc_range_sequencer #(.CLK_HZ(HZ)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rng_req_i  (rng_req),
        .rng_code_i (rng_code),
        .pwr_req_i  (pwr_req),
        .pwr_code_i (pwr_code),
        .conv_req_i (conv_req),
        .rng_sel_o  (rng_sel),
        .sleep_n_o  (sleep_n),
        .nap_o      (nap),
        .ready_o    (ready),
        .conv_go_o  (conv_go)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!ready && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic send(input bit is_pwr, input logic [1:0] code);
        @(negedge clk);
        if (is_pwr) begin pwr_req = 1'b1; pwr_code = code; end
        else        begin rng_req = 1'b1; rng_code = code; end
        @(negedge clk);
        pwr_req = 1'b0;
        rng_req = 1'b0;
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 gain pins at reset", rng_sel, 2'b11);
        chk("R10 ready at reset", ready, 0);
        chk("R10 sleep_n at reset", sleep_n, 1);
        chk("R10 nap at reset", nap, 0);
        rst_n = 1'b1;
        count_low(n);
        chk("R10 start-up wait", n, W_SLEEP);

        // Table walk: R1 pin encoding and R2 R3 R4 R7 wait lengths
        for (int i = 0; i < 6; i++) begin
            send(1'b0, VECS[i].code);
            chk("R1 gain pins after request", rng_sel, VECS[i].code);
            count_low(n);
            chk("table wait length (R2 R3 R4 R7)", n, VECS[i].wait_c);
        end

        // R5: reserved power code is ignored
        send(1'b1, 2'b11);
        chk("R5 reserved code keeps ready", ready, 1);
        chk("R5 reserved code keeps nap", nap, 0);
        chk("R5 reserved code keeps sleep_n", sleep_n, 1);

        // R9: conversion passes when ready
        conv_req = 1'b1;
        @(negedge clk);
        chk("R9 conv passes when ready", conv_go, 1);

        // R8: request during a wait is held then applied
        send(1'b0, 2'b11);
        chk("R8 first level applied", rng_sel, 2'b11);
        chk("R9 conv blocked while settling", conv_go, 0);
        @(negedge clk);
        rng_req = 1'b1; rng_code = 2'b01;
        @(negedge clk);
        rng_req = 1'b0;
        chk("R8 held request leaves pins", rng_sel, 2'b11);
        count_low(n);
        chk("R8 chained wait", n, W_RISE + W_FALL - 2);
        chk("R8 held level applied", rng_sel, 2'b01);
        conv_req = 1'b0;

        // R7: same power state requested
        send(1'b1, 2'b00);
        chk("R7 same power keeps ready", ready, 1);

        // R5 / R6: nap
        send(1'b1, 2'b01);
        chk("R5 nap pin", nap, 1);
        chk("R5 nap sleep_n", sleep_n, 1);
        repeat (5) @(negedge clk);
        chk("R5 ready low in nap", ready, 0);
        send(1'b1, 2'b00);
        chk("R6 nap released", nap, 0);
        count_low(n);
        chk("R6 nap wake wait", n, W_NAP);

        // R5 / R6: sleep
        send(1'b1, 2'b10);
        chk("R5 sleep pin", sleep_n, 0);
        chk("R5 sleep nap pin", nap, 0);
        chk("R5 ready low in sleep", ready, 0);
        send(1'b1, 2'b00);
        chk("R6 sleep released", sleep_n, 1);
        count_low(n);
        chk("R6 sleep wake wait", n, W_SLEEP);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule